// File: doc/BRIEF.md
# Burst Receiver Control Sequencer

This block is the control state machine of a burst-mode phase-shift-keyed receiver. It waits for a burst: each cycle it compares an externally computed presence metric against a programmed threshold. Once a burst is found, it hunts for a programmed sync word in the hard-decision bit stream. A successful match starts a header-estimation phase of fixed length. The block then moves into data demodulation and stays there across any number of frames, until a programmed tail pattern closes the burst.

Bits enter only on the symbol strobe, which fires once every four samples. The estimation engines, the correction loops, the slicer and the decoder all sit outside the block. They see only the enables and pulses it raises. A missed sync word returns the block to hunting. A synchronous abort forces a return to hunting from any state.

Top module: `burst_seq_ctrl`

## Requirements
- R1: During and after reset, `state_out` is 0 (hunting), `search_act` is 1, and `est_en`, `demod_en`, `sod_pulse` and `done_pulse` are 0.
- R2: While hunting, the block moves to sync-word search (`state_out` = 1) at the clock edge after a cycle in which `metric_in` is strictly greater than `thresh_in`. If `metric_in` is equal to or below `thresh_in`, the block stays in hunting.
- R3: Bits are shifted in with the newest bit at the least significant end, so a pattern is sent most significant bit first. After at least PAT_W bits have been shifted in since the state was entered, the last PAT_W bits match `uw_pattern` when they differ in no more than `max_err` positions. On a match, the block enters estimation (`state_out` = 2) and raises `sod_pulse` for exactly one cycle, the first estimation cycle.
- R4: In sync-word search, if no match has occurred by the time `uw_window` bits have been counted, the block returns to hunting without raising `sod_pulse`.
- R5: A bit is taken only in a cycle in which `sym_stb` and `bit_valid` are both 1. Bits presented in any other cycle do not advance the sync-word search, the window, the header count or the tail search.
- R6: Estimation lasts `hdr_len` bits and then passes to demodulation (`state_out` = 3). `est_en` is 1 exactly while in estimation, and `demod_en` exactly while in demodulation. The two are never 1 together.
- R7: In demodulation, each cycle with `frame_bound` set adds one to a saturating frame count. Frame boundaries never end demodulation.
- R8: In demodulation, a match of the tail pattern `eob_pattern` returns the block to hunting, with the same error tolerance as R3. In the first hunting cycle, `done_pulse` is 1 for one cycle and `done_frames` holds the frame count of the burst.
- R9: `abort` set in any cycle puts the block in hunting at the next edge, with both enables 0. It clears all counters and raises no `done_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| abort | input | 1 | Force return to hunting, clear counters |
| metric_in | input | METRIC_W | Burst presence metric |
| thresh_in | input | METRIC_W | Detection threshold |
| sym_stb | input | 1 | One-in-four symbol strobe |
| bit_valid | input | 1 | Hard-decision bit is valid |
| bit_in | input | 1 | Hard-decision bit |
| uw_pattern | input | PAT_W | Sync word |
| eob_pattern | input | PAT_W | Tail pattern marking end of burst |
| max_err | input | ERR_W | Allowed mismatched bits per match |
| uw_window | input | WIN_W | Sync-word search window in bits |
| hdr_len | input | HDR_W | Header length in bits |
| frame_bound | input | 1 | Frame boundary strobe from downstream |
| state_out | output | 2 | 0 hunt, 1 sync search, 2 estimate, 3 demodulate |
| search_act | output | 1 | Block is hunting for a burst |
| est_en | output | 1 | Enable for header estimation engines |
| demod_en | output | 1 | Enable for correction loops and slicer |
| sod_pulse | output | 1 | Start of data marker |
| done_pulse | output | 1 | Burst ended by tail pattern |
| done_frames | output | FRM_W | Frame count of the finished burst |

## Verification
An error in the state register or in one of the counters shows up at `state_out` and the enables. It appears at the clock edge after the bit that should have moved the block: a late sync match or a window that expires early shifts that edge by a whole symbol. A wrong popcount or a wrong bit order shows up as a missing or unexpected `sod_pulse` when the last pattern bit arrives. A counter that is not cleared shows up as a wrong `done_frames` in a later burst.

// File: rtl/brx_pkg.sv
package brx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_UWS  = 2'd1,
    ST_EST  = 2'd2,
    ST_DEM  = 2'd3
  } brx_state_e;
endpackage

// File: rtl/brx_event_counter.sv
module brx_event_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX); // R7
endmodule

// File: rtl/brx_bit_window.sv
module brx_bit_window #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] word,
  output logic         full
);
  localparam int FW = $clog2(W + 1);
  localparam logic [FW-1:0] FILL_MAX = FW'(W);

  logic [FW-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      word   <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      word <= {word[W-2:0], bit_in};
      if (fill_q != FILL_MAX) fill_q <= fill_q + 1'b1;
    end
  end

  assign full = (fill_q == FILL_MAX);

  AST_NO_SHIFT_WITHOUT_STB: assert property (@(posedge clk) disable iff (rst)
    (!shift_en && !clr) |=> $stable(word)); // R5
endmodule

// File: rtl/brx_pattern_match.sv
module brx_pattern_match #(
  parameter int W     = 32,
  parameter int ERR_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     word,
  input  logic [W-1:0]     pattern,
  input  logic             full,
  input  logic [ERR_W-1:0] max_err,
  output logic             hit
);
  logic [W-1:0]     diff;
  logic [ERR_W-1:0] errs;

  for (genvar i = 0; i < W; i++) begin : g_diff
    assign diff[i] = word[i] ^ pattern[i];
  end

  always_comb begin
    errs = '0;
    for (int i = 0; i < W; i++) errs = errs + ERR_W'(diff[i]);
  end

  assign hit = full && (errs <= max_err);
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import brx_pkg::*;
#(
  parameter int METRIC_W = 16,
  parameter int PAT_W    = 32,
  parameter int ERR_W    = $clog2(PAT_W + 1),
  parameter int WIN_W    = 16,
  parameter int HDR_W    = 12,
  parameter int FRM_W    = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                abort,
  input  logic [METRIC_W-1:0] metric_in,
  input  logic [METRIC_W-1:0] thresh_in,
  input  logic                sym_stb,
  input  logic                bit_valid,
  input  logic                bit_in,
  input  logic [PAT_W-1:0]    uw_pattern,
  input  logic [PAT_W-1:0]    eob_pattern,
  input  logic [ERR_W-1:0]    max_err,
  input  logic [WIN_W-1:0]    uw_window,
  input  logic [HDR_W-1:0]    hdr_len,
  input  logic                frame_bound,
  output logic [1:0]          state_out,
  output logic                search_act,
  output logic                est_en,
  output logic                demod_en,
  output logic                sod_pulse,
  output logic                done_pulse,
  output logic [FRM_W-1:0]    done_frames
);
  brx_state_e state_q, nxt;
  logic bit_ev, trans, clr_all;
  logic uw_hit, eob_hit, win_full;
  logic [PAT_W-1:0] word;
  logic [WIN_W-1:0] win_cnt;
  logic [HDR_W-1:0] hdr_cnt;
  logic [FRM_W-1:0] frm_cnt;

  assign bit_ev  = sym_stb && bit_valid;
  assign trans   = (nxt != state_q);
  assign clr_all = trans || abort;

  brx_bit_window #(.W(PAT_W)) u_window (
    .clk(clk), .rst(rst), .clr(clr_all), .shift_en(bit_ev),
    .bit_in(bit_in), .word(word), .full(win_full)
  );

  brx_pattern_match #(.W(PAT_W), .ERR_W(ERR_W)) u_uw_match (
    .word(word), .pattern(uw_pattern), .full(win_full),
    .max_err(max_err), .hit(uw_hit)
  );

  brx_pattern_match #(.W(PAT_W), .ERR_W(ERR_W)) u_eob_match (
    .word(word), .pattern(eob_pattern), .full(win_full),
    .max_err(max_err), .hit(eob_hit)
  );

  brx_event_counter #(.W(WIN_W)) u_win_cnt (
    .clk(clk), .rst(rst), .clr(clr_all),
    .inc(bit_ev && state_q == ST_UWS), .cnt(win_cnt)
  );

  brx_event_counter #(.W(HDR_W)) u_hdr_cnt (
    .clk(clk), .rst(rst), .clr(clr_all),
    .inc(bit_ev && state_q == ST_EST), .cnt(hdr_cnt)
  );

  brx_event_counter #(.W(FRM_W)) u_frm_cnt (
    .clk(clk), .rst(rst), .clr(clr_all),
    .inc(frame_bound && state_q == ST_DEM), .cnt(frm_cnt)
  );

  always_comb begin
    nxt = state_q;
    if (abort) nxt = ST_HUNT;
    else begin
      unique case (state_q)
        ST_HUNT: if (metric_in > thresh_in) nxt = ST_UWS;
        ST_UWS: begin
          if (uw_hit) nxt = ST_EST;
          else if (win_cnt >= uw_window) nxt = ST_HUNT;
        end
        ST_EST: if (hdr_cnt >= hdr_len) nxt = ST_DEM;
        ST_DEM: if (eob_hit) nxt = ST_HUNT;
        default: nxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_HUNT;
      search_act  <= 1'b1;
      est_en      <= 1'b0;
      demod_en    <= 1'b0;
      sod_pulse   <= 1'b0;
      done_pulse  <= 1'b0;
      done_frames <= '0;
    end else begin
      state_q    <= nxt;
      search_act <= (nxt == ST_HUNT);
      est_en     <= (nxt == ST_EST);
      demod_en   <= (nxt == ST_DEM);
      sod_pulse  <= !abort && state_q == ST_UWS && nxt == ST_EST;
      done_pulse <= !abort && state_q == ST_DEM && nxt == ST_HUNT;
      if (!abort && state_q == ST_DEM && nxt == ST_HUNT) done_frames <= frm_cnt;
    end
  end

  assign state_out = state_q;

  AST_EST_DEMOD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(est_en && demod_en)); // R6
  AST_SOD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sod_pulse |=> !sod_pulse); // R3
  AST_SOD_IN_EST: assert property (@(posedge clk) disable iff (rst)
    sod_pulse |-> (est_en && state_out == 2'd2)); // R3
  AST_DONE_IN_HUNT: assert property (@(posedge clk) disable iff (rst)
    done_pulse |-> (search_act && state_out == 2'd0)); // R8
  AST_ABORT_HUNT: assert property (@(posedge clk) disable iff (rst)
    abort |=> (state_out == 2'd0 && !est_en && !demod_en && !done_pulse)); // R9
  AST_HUNT_EXIT_ONLY_UWS: assert property (@(posedge clk) disable iff (rst)
    (state_out == 2'd0 && !abort) |=> (state_out == 2'd0 || state_out == 2'd1)); // R2
endmodule

// File: tb/burst_seq_ctrl_tb.sv
module burst_seq_ctrl_tb;
  localparam int PAT_W = 32;
  localparam int ERR_W = $clog2(PAT_W + 1);
  localparam logic [31:0] UW  = 32'hA5C3_1E7B;
  localparam logic [31:0] EOB = 32'h0F0F_3C3C;
  localparam int NVEC = 6;
  // {metric, threshold, expect sync search}
  localparam logic [32:0] VEC [NVEC] = '{
    {16'd100,   16'd99,    1'b1},
    {16'd99,    16'd99,    1'b0},
    {16'd0,     16'd0,     1'b0},
    {16'hFFFF,  16'hFFFE,  1'b1},
    {16'd5,     16'd200,   1'b0},
    {16'd1,     16'd0,     1'b1}
  };

  logic clk = 0, rst = 1, abort = 0;
  logic [15:0] metric_in = 0, thresh_in = 0;
  logic sym_stb = 0, bit_valid = 0, bit_in = 0, frame_bound = 0;
  logic [PAT_W-1:0] uw_pattern = UW, eob_pattern = EOB;
  logic [ERR_W-1:0] max_err = 2;
  logic [15:0] uw_window = 16'd40;
  logic [11:0] hdr_len = 12'd8;
  logic [1:0] state_out;
  logic search_act, est_en, demod_en, sod_pulse, done_pulse;
  logic [7:0] done_frames;

  int checks = 0, errors = 0, sod_cnt = 0, done_cnt = 0;
  logic [7:0] last_frames = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  burst_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .abort(abort), .metric_in(metric_in), .thresh_in(thresh_in),
    .sym_stb(sym_stb), .bit_valid(bit_valid), .bit_in(bit_in),
    .uw_pattern(uw_pattern), .eob_pattern(eob_pattern), .max_err(max_err),
    .uw_window(uw_window), .hdr_len(hdr_len), .frame_bound(frame_bound),
    .state_out(state_out), .search_act(search_act), .est_en(est_en),
    .demod_en(demod_en), .sod_pulse(sod_pulse), .done_pulse(done_pulse),
    .done_frames(done_frames)
  );

  always @(negedge clk) begin
    if (sod_pulse) sod_cnt++;
    if (done_pulse) begin done_cnt++; last_frames = done_frames; end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic stb = 1'b1, input logic vld = 1'b1);
    sym_stb = stb; bit_valid = vld; bit_in = b;
    step();
    sym_stb = 0; bit_valid = 0;
    repeat (3) step();
  endtask

  task automatic send_word(input logic [31:0] w, input logic stb = 1'b1);
    for (int i = 31; i >= 0; i--) send_bit(w[i], stb);
  endtask

  task automatic do_abort();
    abort = 1; step(); abort = 0; step();
  endtask

  task automatic start_burst();
    metric_in = 16'd500; thresh_in = 16'd100; step(); metric_in = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int s0;
    repeat (3) step();
    chk(state_out == 0 && search_act && !est_en && !demod_en, "R1 reset state", state_out, 0);
    rst = 0; step();
    chk(state_out == 0 && !sod_pulse && !done_pulse, "R1 after reset", state_out, 0);

    // R2 threshold table
    for (int v = 0; v < NVEC; v++) begin
      metric_in = VEC[v][32:17]; thresh_in = VEC[v][16:1];
      step();
      metric_in = 0; thresh_in = 0;
      chk(state_out == (VEC[v][0] ? 2'd1 : 2'd0), "R2 threshold vector", state_out, VEC[v][0]);
      do_abort();
    end

    // Full burst: R3 R6 R7 R8
    uw_window = 16'd40; max_err = 2; hdr_len = 12'd8;
    s0 = sod_cnt;
    start_burst();
    send_word(UW);
    chk(state_out == 2 && est_en && !demod_en, "R3 sync match enters estimate", state_out, 2);
    chk(sod_cnt == s0 + 1, "R3 single start-of-data pulse", sod_cnt - s0, 1);
    for (int i = 0; i < 7; i++) send_bit(1'b0);
    chk(state_out == 2 && est_en, "R6 estimate holds before header end", state_out, 2);
    send_bit(1'b0);
    chk(state_out == 3 && demod_en && !est_en, "R6 header end enters demodulate", state_out, 3);
    for (int i = 0; i < 3; i++) begin frame_bound = 1; step(); frame_bound = 0; step(); end
    chk(state_out == 3 && demod_en, "R7 frames keep demodulate", state_out, 3);
    s0 = done_cnt;
    send_word(EOB);
    chk(state_out == 0 && search_act && !demod_en, "R8 tail returns to hunt", state_out, 0);
    chk(done_cnt == s0 + 1 && last_frames == 8'd3, "R8 done pulse frame count", last_frames, 3);

    // R4 window expiry
    s0 = sod_cnt;
    start_burst();
    for (int i = 0; i < 39; i++) send_bit(1'b0);
    chk(state_out == 1, "R4 still searching inside window", state_out, 1);
    send_bit(1'b0);
    chk(state_out == 0 && sod_cnt == s0, "R4 window miss back to hunt", state_out, 0);

    // R3 error tolerance
    uw_window = 16'd32;
    start_burst();
    send_word(UW ^ 32'h0001_0001);
    chk(state_out == 2, "R3 two bit errors accepted", state_out, 2);
    do_abort();
    s0 = sod_cnt;
    start_burst();
    send_word(UW ^ 32'h1001_0001);
    chk(state_out == 0 && sod_cnt == s0, "R3 three bit errors rejected", state_out, 0);

    // R5 gating
    start_burst();
    send_word(UW, 1'b0);
    chk(state_out == 1, "R5 bits without strobe ignored", state_out, 1);
    for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b1, 1'b0);
    chk(state_out == 1, "R5 strobe without valid ignored", state_out, 1);
    send_word(UW);
    chk(state_out == 2, "R5 strobed bits counted", state_out, 2);

    // R9 abort in demodulate
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    frame_bound = 1; step(); step(); frame_bound = 0; step();
    s0 = done_cnt;
    abort = 1; step(); abort = 0;
    chk(state_out == 0 && !est_en && !demod_en, "R9 abort to hunt", state_out, 0);
    step();
    chk(done_cnt == s0, "R9 abort gives no done pulse", done_cnt - s0, 0);
    start_burst();
    send_word(UW);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    frame_bound = 1; step(); frame_bound = 0; step();
    send_word(EOB);
    chk(last_frames == 8'd1 && done_cnt == s0 + 1, "R9 counters cleared by abort", last_frames, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule